// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a small binary counter with two count strobes instead of one direction bit. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe subtracts one. The strobe that is not in use must be held high. Both strobes are asynchronous to the block. They pass through a two-stage synchronizer clocked by a fast system clock, and the block detects their edges against a registered copy of the synchronized level. The count wraps modulo 2^CNT_W.

Two controls take precedence over counting:

- **Clear** (active high) forces the count to zero.
- **Load** (active low) copies the data input into the count.

Both controls ignore the strobes and act at the next system clock edge. Clear wins over load.

The block has two active-low terminal outputs:

- **Carry** drops while the count is at its maximum and the synchronized up strobe is low.
- **Borrow** drops while the count is zero and the synchronized down strobe is low.

Each terminal output follows its strobe's waveform at the terminal count. Wiring carry into the next stage's up strobe and borrow into its down strobe therefore builds a wider counter.

If one strobe rises while the other is low, or both rise in the same sample, the edge is ignored. In that case a sticky error flag is set, and only a clear or the system reset removes it.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb_i` while `dn_stb_i` is high adds one to `count_o`, and 15 advances to 0. The new value appears by the third system clock edge after the pin change (two synchronizer stages plus the edge register).
- R2: A rising edge on `dn_stb_i` while `up_stb_i` is high subtracts one from `count_o`, and 0 retreats to 15, with the same latency as R1.
- R3: While `clr_i` is 1, the next clock edge sets `count_o` to 0 and `err_o` to 0, whatever `load_n_i`, `data_i` and the strobes are doing.
- R4: While `load_n_i` is 0 and `clr_i` is 0, the next clock edge copies `data_i` into `count_o`. Strobe edges seen during that time do not change the count.
- R5: `carry_n_o` is 0 exactly when `count_o` is 15 and the synchronized up strobe is low; otherwise it is 1.
- R6: `borrow_n_o` is 0 exactly when `count_o` is 0 and the synchronized down strobe is low; otherwise it is 1.
- R7: A strobe that is low during a clear or load and stays low after the control is released is counted on its next rising edge.
- R8: A rising edge of one strobe while the other is low, or of both in the same sample, leaves the count unchanged and sets `err_o` to 1. `err_o` then stays 1 until a clear.
- R9: After the system reset `rst` (synchronous, active high), `count_o` is 0, `carry_n_o` and `borrow_n_o` are 1, and `err_o` is 0. The synchronizers start at the idle-high level, so no edge is counted on leaving reset.
- R10: Clear, a load of 13, five up strobes and five down strobes give the counts 0, 13, 14, 15, 0, 1, 2, 1, 0, 15, 14, 13.
- R11: When two stages share clear and load, the low stage's carry drives the high stage's up strobe and its borrow drives the high stage's down strobe. The pair then counts as one 8-bit up/down counter, including across the 0x3F/0x40 boundary in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high system reset |
| clr_i | input | 1 | Active-high clear; highest priority |
| load_n_i | input | 1 | Active-low parallel load |
| data_i | input | CNT_W | Value copied into the count on load |
| up_stb_i | input | 1 | Up count strobe; counts on rising edge, idle high |
| dn_stb_i | input | 1 | Down count strobe; counts on rising edge, idle high |
| count_o | output | CNT_W | Current count |
| carry_n_o | output | 1 | Active-low carry; follows the up strobe at maximum count |
| borrow_n_o | output | 1 | Active-low borrow; follows the down strobe at zero count |
| err_o | output | 1 | Sticky flag for an illegal strobe edge |

## Verification
The counting path is tested with several input patterns:

- Runs of up strobes only, which expose wrap at the top.
- Runs of down strobes only, which expose wrap at the bottom.
- An up strobe with the down strobe held low, which separates a legal edge from an illegal one and checks that the later release of the held strobe counts as a normal down step.
- Strobes toggled while load or clear is held, which shows that the controls mask counting.
- A strobe kept low across a load or clear and raised afterwards, which shows that the edge is kept rather than swallowed.

A second stage chained on carry and borrow checks that the terminal outputs are clean strobes. A wrong pulse shape shows up as a high-nibble error at the 0x3F/0x40 boundary.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int unsigned DEF_CNT_W   = 4;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned NUM_STB     = 2;
    localparam int unsigned STB_UP      = 0;
    localparam int unsigned STB_DN      = 1;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_INC,
        OP_DEC,
        OP_BAD
    } cnt_op_e;

    typedef struct packed {
        logic lvl;
        logic rise;
    } stb_t;

    // Priority: clear, then load, then legal strobe edges.
    function automatic cnt_op_e pick_op(input logic clr, input logic load_n,
                                        input stb_t up, input stb_t dn);
        if (clr)                    return OP_CLEAR;
        if (!load_n)                return OP_LOAD;
        if (up.rise && dn.rise)     return OP_BAD;
        if (up.rise)                return dn.lvl ? OP_INC : OP_BAD;
        if (dn.rise)                return up.lvl ? OP_DEC : OP_BAD;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync
    import updn_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    output stb_t stb_o
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], stb_i};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    always_comb begin
        stb_o.lvl  = shift_q[STAGES-1];
        stb_o.rise = shift_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (op_i)
                OP_CLEAR: begin
                    count_q <= '0;
                    err_q   <= 1'b0;
                end
                OP_LOAD:  count_q <= data_i;
                OP_INC:   count_q <= count_q + ONE;
                OP_DEC:   count_q <= count_q - ONE;
                OP_BAD:   err_q   <= 1'b1;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count_o = count_q;
    assign err_o   = err_q;
endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
    parameter int unsigned CNT_W = 4
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             up_lvl_i,
    input  logic             dn_lvl_i,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic at_top;
    logic at_zero;

    always_comb begin
        at_top     = (count_i == TOP);
        at_zero    = (count_i == '0);
        carry_n_o  = ~(at_top  & ~up_lvl_i);
        borrow_n_o = ~(at_zero & ~dn_lvl_i);
    end
endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
    import updn_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             load_n_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             up_stb_i,
    input  logic             dn_stb_i,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o,
    output logic             err_o
);
    logic [NUM_STB-1:0] raw_stb;
    stb_t               stb [NUM_STB];
    cnt_op_e            op;
    logic [CNT_W-1:0]   count;

    assign raw_stb[STB_UP] = up_stb_i;
    assign raw_stb[STB_DN] = dn_stb_i;

    for (genvar g = 0; g < NUM_STB; g++) begin : g_sync
        updn_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .stb_i (raw_stb[g]),
            .stb_o (stb[g])
        );
    end

    assign op = pick_op(clr_i, load_n_i, stb[STB_UP], stb[STB_DN]);

    updn_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .data_i  (data_i),
        .count_o (count),
        .err_o   (err_o)
    );

    updn_term_detect #(.CNT_W(CNT_W)) u_term (
        .count_i    (count),
        .up_lvl_i   (stb[STB_UP].lvl),
        .dn_lvl_i   (stb[STB_DN].lvl),
        .carry_n_o  (carry_n_o),
        .borrow_n_o (borrow_n_o)
    );

    assign count_o = count;
endmodule

// File: rtl/updn_strobe_counter_chk.sv
module updn_strobe_counter_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             load_n_i,
    input logic [CNT_W-1:0] data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             err_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0) && !err_o); // R3

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !load_n_i) |=> count_o == $past(data_i)); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && load_n_i) |=> (count_o == $past(count_o) ||
                                  count_o == $past(count_o) + ONE ||
                                  count_o == $past(count_o) - ONE)); // R1

    AST_CARRY_ONLY_TOP: assert property (@(posedge clk) disable iff (rst)
        (count_o != TOP) |-> carry_n_o); // R5

    AST_BORROW_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count_o != '0) |-> borrow_n_o); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_o && !clr_i) |=> err_o); // R8

    AST_ERR_ON_RESET: assert property (@(posedge clk)
        $past(rst) |-> !err_o && count_o == '0); // R9
endmodule

bind updn_strobe_counter updn_strobe_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .load_n_i   (load_n_i),
    .data_i     (data_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o),
    .err_o      (err_o)
);

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data_lo = '0;
    logic [3:0] data_hi = '0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic [3:0] cnt_lo, cnt_hi;
    logic       carry_lo, borrow_lo, err_lo;
    logic       carry_hi, borrow_hi, err_hi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    updn_strobe_counter #(.CNT_W(4)) u_dut (
        .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .data_i(data_lo),
        .up_stb_i(up), .dn_stb_i(dn), .count_o(cnt_lo),
        .carry_n_o(carry_lo), .borrow_n_o(borrow_lo), .err_o(err_lo)
    );

    updn_strobe_counter #(.CNT_W(4)) u_hi (
        .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .data_i(data_hi),
        .up_stb_i(carry_lo), .dn_stb_i(borrow_lo), .count_o(cnt_hi),
        .carry_n_o(carry_hi), .borrow_n_o(borrow_hi), .err_o(err_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One strobe pulse: low phase, sample the terminal output, high phase.
    task automatic pulse(input bit is_up, output logic tc_low_phase);
        @(negedge clk);
        if (is_up) up = 1'b0; else dn = 1'b0;
        wait_n(5);
        tc_low_phase = is_up ? carry_lo : borrow_lo;
        if (is_up) up = 1'b1; else dn = 1'b1;
        wait_n(6);
    endtask

    task automatic do_load(input logic [3:0] lo, input logic [3:0] hi);
        @(negedge clk);
        data_lo = lo; data_hi = hi; load_n = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        wait_n(1);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        wait_n(2);
        clr = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset();
        wait_n(3);
        rst = 1'b0;
        wait_n(4);
        chk("R9 count", cnt_lo, 0);
        chk("R9 carry", carry_lo, 1);
        chk("R9 borrow", borrow_lo, 1);
        chk("R9 err", err_lo, 0);
    endtask

    task automatic t_sequence();
        logic tc;
        int exp;
        do_clear();
        chk("R10 clear", cnt_lo, 0);
        do_load(4'd13, 4'd0);
        chk("R10 load13", cnt_lo, 13);
        exp = 13;
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1, tc);
            chk("R5 carry during up low", tc, (exp == 15) ? 0 : 1);
            exp = (exp + 1) % 16;
            chk("R1 R10 up step", cnt_lo, exp);
        end
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0, tc);
            chk("R6 borrow during down low", tc, (exp == 0) ? 0 : 1);
            exp = (exp + 15) % 16;
            chk("R2 R10 down step", cnt_lo, exp);
        end
        chk("R10 final", cnt_lo, 13);
    endtask

    task automatic t_illegal();
        do_load(4'd8, 4'd0);
        @(negedge clk); dn = 1'b0;
        wait_n(5);
        @(negedge clk); up = 1'b0;
        wait_n(5);
        up = 1'b1;
        wait_n(6);
        chk("R8 count held", cnt_lo, 8);
        chk("R8 err set", err_lo, 1);
        dn = 1'b1;
        wait_n(6);
        chk("R8 legal down after", cnt_lo, 7);
        chk("R8 err sticky", err_lo, 1);
    endtask

    task automatic t_clear();
        logic tc;
        @(negedge clk);
        clr = 1'b1; load_n = 1'b0; data_lo = 4'd9;
        up = 1'b0;
        wait_n(5);
        up = 1'b1;
        wait_n(6);
        chk("R3 count zero over load+strobe", cnt_lo, 0);
        chk("R3 err cleared", err_lo, 0);
        clr = 1'b0; load_n = 1'b1;
        wait_n(2);
        pulse(1'b0, tc);
        chk("R2 wrap 0 to 15", cnt_lo, 15);
    endtask

    task automatic t_load();
        @(negedge clk);
        load_n = 1'b0; data_lo = 4'd5;
        up = 1'b0; wait_n(5); up = 1'b1; wait_n(6);
        dn = 1'b0; wait_n(5); dn = 1'b1; wait_n(6);
        chk("R4 load masks strobes", cnt_lo, 5);
        load_n = 1'b1;
        wait_n(2);
        chk("R4 hold after load", cnt_lo, 5);
    endtask

    task automatic t_low_through();
        @(negedge clk); up = 1'b0;
        wait_n(5);
        do_load(4'd7, 4'd0);
        up = 1'b1;
        wait_n(6);
        chk("R7 edge after load counted", cnt_lo, 8);
        @(negedge clk); dn = 1'b0;
        wait_n(5);
        do_clear();
        dn = 1'b1;
        wait_n(6);
        chk("R7 edge after clear counted", cnt_lo, 15);
    endtask

    task automatic t_chain();
        logic tc;
        int exp;
        do_clear();
        do_load(4'd14, 4'd3);
        chk("R11 preset", {cnt_hi, cnt_lo}, 8'h3E);
        exp = 8'h3E;
        for (int i = 0; i < 4; i++) begin
            pulse(1'b1, tc);
            exp = (exp + 1) % 256;
            chk("R11 chained up", {cnt_hi, cnt_lo}, exp);
        end
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0, tc);
            exp = (exp + 255) % 256;
            chk("R11 chained down", {cnt_hi, cnt_lo}, exp);
        end
        chk("R11 upper stage no error", err_hi, 0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_illegal();
        t_clear();
        t_load();
        t_low_through();
        t_chain();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule